// File: doc/BRIEF.md
# Pipeline Stall Controller

This block is the central freeze and bubble logic for a six-stage in-order pipeline whose positions are PC, IF, ID, EX, MEM and WB. Three sources can ask for a freeze. The fetch side asks while it waits on the bus. Decode asks when it detects a load-use hazard, and the detector for that hazard is part of the block. Execute asks while a multi-cycle multiply-accumulate or divide is running. The block combines these requests into a 6-bit hold vector and forwards a flush strobe.

For the stage that asks, every earlier stage is frozen and the requesting stage sends a nop forward. The stages after it keep draining. A flush beats every request.

The block also contains the four stage-boundary registers (IF/ID, ID/EX, EX/MEM, MEM/WB), which are built from one shared template. In this block the stages do no work, so each boundary register is fed from the one before it, and the IF/ID register is fed from the fetch payload input. This lets the freeze, bubble and drain pattern be seen directly at the ports. The nop encoding is all zeros.

Top module: `pipe_stall_unit`

## Requirements
- R1: After reset, every boundary register reads zero, and with no request active the hold vector is 6'b000000.
- R2: A fetch wait on its own gives hold vector 6'b000111, where bit 0 is PC, bit 1 is IF, bit 2 is ID, bit 3 is EX, bit 4 is MEM and bit 5 is WB.
- R3: A load-use request on its own gives hold vector 6'b000111.
- R4: A multiply-accumulate request or a divide request, alone or together, gives hold vector 6'b001111.
- R5: When several requests are active, the latest requesting stage sets the vector, so an execute request overrides decode and fetch requests.
- R6: Flush overrides every request. While flush is high the hold vector is 6'b000000 and flushOut is 1, and on the next clock edge every boundary register becomes zero.
- R7: loadUseReq is 1 when the EX instruction is a load that writes a register, its destination is nonzero, and the destination equals idSrcA or idSrcB.
- R8: loadUseReq is 0 when the destination is register 0, when the EX instruction does not write a register, or when it is not a load, even if the register numbers match.
- R9: A boundary register whose source stage is held while the following stage is not held loads the nop value (zero) on the clock edge.
- R10: A boundary register holds its value when both its source stage and the following stage are held.
- R11: With no hold on its source stage, a boundary register takes its input on each edge. Boundary j sits in bndData[j*DATA_W +: DATA_W], where j=0 is IF/ID and j=3 is MEM/WB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flushIn | input | 1 | Pipeline flush request |
| fetchWait | input | 1 | Fetch side waiting on the bus |
| macBusy | input | 1 | Multiply-accumulate needs another cycle |
| divBusy | input | 1 | Divider needs another cycle |
| exIsLoad | input | 1 | Instruction in EX is a load |
| exWrEn | input | 1 | Instruction in EX writes a register |
| exDestReg | input | REG_AW | Destination register of the EX instruction |
| idSrcA | input | REG_AW | First source register read in ID |
| idSrcB | input | REG_AW | Second source register read in ID |
| fetchPayload | input | DATA_W | Word entering the IF/ID boundary |
| holdVec | output | 6 | Per-stage hold vector |
| flushOut | output | 1 | Flush strobe to all stages |
| loadUseReq | output | 1 | Decode-side stall request from the hazard detector |
| bndData | output | 4*DATA_W | Boundary register contents, IF/ID in the low slice |

## Verification
On every cycle, the assertions check that the hold vector is a contiguous run of ones starting at the PC bit, that flush zeroes the vector, and that an execute request stops the run at EX. At each boundary register they check the hold, bubble, pass and flush rules, one edge after the cause. They also check that the hazard detector never fires on register 0 or on a non-load. Only the bench's scenarios show the exact vectors for fetch-only and decode-only requests, the resolution when several sources request together, and the pattern that results across all four boundaries. In that pattern earlier boundaries stay put, one boundary turns into a bubble and the later ones drain, and this is checked against known payload values.

// File: rtl/stall_pkg.sv
package stall_pkg;
  localparam int unsigned NUM_STAGES = 6;
  localparam int unsigned NUM_BND    = NUM_STAGES - 2;

  // Encoded as the index of the last stage that is frozen.
  typedef enum logic [2:0] {
    FRZ_NONE = 3'd0,
    FRZ_ID   = 3'd2,
    FRZ_EX   = 3'd3
  } freezeEdge_t;

  typedef struct packed {
    logic [NUM_STAGES-1:0] hold;
    logic                  flush;
  } stallCtl_t;

  function automatic logic [NUM_STAGES-1:0] holdMask(freezeEdge_t edgeSel);
    logic [NUM_STAGES-1:0] m;
    m = '0;
    if (edgeSel != FRZ_NONE) begin
      for (int i = 0; i < NUM_STAGES; i++) begin
        m[i] = (i <= int'(edgeSel));
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/stall_ctrl.sv
module stall_ctrl
  import stall_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      flushIn,
  input  logic      fetchWait,
  input  logic      loadUseReq,
  input  logic      macBusy,
  input  logic      divBusy,
  output stallCtl_t ctl
);
  freezeEdge_t lastEdge;
  logic        exReq;

  assign exReq = macBusy | divBusy;

  // Later stages are checked last so that they win.
  always_comb begin
    lastEdge = FRZ_NONE;
    if (fetchWait)  lastEdge = FRZ_ID;
    if (loadUseReq) lastEdge = FRZ_ID;
    if (exReq)      lastEdge = FRZ_EX;
  end

  always_comb begin
    ctl.flush = flushIn;
    ctl.hold  = flushIn ? '0 : holdMask(lastEdge);
  end

  // R5: the vector is always a run of ones anchored at the PC bit
  a_r5_contiguous: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl.hold + 1'b1));
  // R6: flush forces the vector to zero
  a_r6_flush_vec: assert property (@(posedge clk) disable iff (!rstN)
    flushIn |-> (ctl.hold == '0));
  // R4: an execute request stops the frozen run at EX
  a_r4_ex_edge: assert property (@(posedge clk) disable iff (!rstN)
    (exReq && !flushIn) |-> (ctl.hold[3] && !ctl.hold[4]));
endmodule

// File: rtl/pipe_bnd_reg.sv
module pipe_bnd_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         flush,
  input  logic         holdHere,
  input  logic         holdNext,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] qOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      qOut <= '0;
    else if (flush)                 qOut <= '0;
    else if (holdHere && !holdNext) qOut <= '0;
    else if (!holdHere)             qOut <= dIn;
  end

  // R10: frozen on both sides keeps the value
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (holdHere && holdNext && !flush) |=> $stable(qOut));
  // R9: requester boundary emits a bubble
  a_r9_bubble: assert property (@(posedge clk) disable iff (!rstN)
    (holdHere && !holdNext && !flush) |=> (qOut == '0));
  // R11: unfrozen boundary passes its input
  a_r11_pass: assert property (@(posedge clk) disable iff (!rstN)
    (!holdHere && !flush) |=> (qOut == $past(dIn)));
  // R6: flush clears the register
  a_r6_flush_reg: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (qOut == '0));
endmodule

// File: rtl/stall_datapath.sv
module stall_datapath
  import stall_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REG_AW = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  stallCtl_t                 ctl,
  input  logic                      exIsLoad,
  input  logic                      exWrEn,
  input  logic [REG_AW-1:0]         exDestReg,
  input  logic [REG_AW-1:0]         idSrcA,
  input  logic [REG_AW-1:0]         idSrcB,
  input  logic [DATA_W-1:0]         fetchPayload,
  output logic                      loadUseReq,
  output logic [NUM_BND*DATA_W-1:0] bndData
);
  logic destLive;
  logic srcHit;

  assign destLive   = exIsLoad && exWrEn && (exDestReg != '0);
  assign srcHit     = (exDestReg == idSrcA) || (exDestReg == idSrcB);
  assign loadUseReq = destLive && srcHit;

  logic [DATA_W-1:0] chain [NUM_BND+1];
  assign chain[0] = fetchPayload;

  for (genvar j = 0; j < NUM_BND; j++) begin : g_bnd
    pipe_bnd_reg #(.W(DATA_W)) u_reg (
      .clk      (clk),
      .rstN     (rstN),
      .flush    (ctl.flush),
      .holdHere (ctl.hold[j+1]),
      .holdNext (ctl.hold[j+2]),
      .dIn      (chain[j]),
      .qOut     (chain[j+1])
    );
    assign bndData[j*DATA_W +: DATA_W] = chain[j+1];
  end

  // R8: register 0 never causes a load-use request
  a_r8_zero_reg: assert property (@(posedge clk) disable iff (!rstN)
    (exDestReg == '0) |-> !loadUseReq);
  // R7: a request needs a writing load in EX
  a_r7_needs_load: assert property (@(posedge clk) disable iff (!rstN)
    loadUseReq |-> (exIsLoad && exWrEn));
endmodule

// File: rtl/pipe_stall_unit.sv
module pipe_stall_unit
  import stall_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REG_AW = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      flushIn,
  input  logic                      fetchWait,
  input  logic                      macBusy,
  input  logic                      divBusy,
  input  logic                      exIsLoad,
  input  logic                      exWrEn,
  input  logic [REG_AW-1:0]         exDestReg,
  input  logic [REG_AW-1:0]         idSrcA,
  input  logic [REG_AW-1:0]         idSrcB,
  input  logic [DATA_W-1:0]         fetchPayload,
  output logic [NUM_STAGES-1:0]     holdVec,
  output logic                      flushOut,
  output logic                      loadUseReq,
  output logic [NUM_BND*DATA_W-1:0] bndData
);
  stallCtl_t ctl;

  stall_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .flushIn    (flushIn),
    .fetchWait  (fetchWait),
    .loadUseReq (loadUseReq),
    .macBusy    (macBusy),
    .divBusy    (divBusy),
    .ctl        (ctl)
  );

  stall_datapath #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .exIsLoad     (exIsLoad),
    .exWrEn       (exWrEn),
    .exDestReg    (exDestReg),
    .idSrcA       (idSrcA),
    .idSrcB       (idSrcB),
    .fetchPayload (fetchPayload),
    .loadUseReq   (loadUseReq),
    .bndData      (bndData)
  );

  assign holdVec  = ctl.hold;
  assign flushOut = ctl.flush;
endmodule

// File: tb/pipe_stall_unit_tb.sv
module pipe_stall_unit_tb;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          flushIn = 0, fetchWait = 0, macBusy = 0, divBusy = 0;
  logic          exIsLoad = 0, exWrEn = 0;
  logic [4:0]    exDestReg = '0, idSrcA = '0, idSrcB = '0;
  logic [DW-1:0] fetchPayload = '0;
  logic [5:0]    holdVec;
  logic          flushOut, loadUseReq;
  logic [4*DW-1:0] bndData;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pipe_stall_unit #(.DATA_W(DW), .REG_AW(5)) u_dut (
    .clk(clk), .rstN(rstN), .flushIn(flushIn), .fetchWait(fetchWait),
    .macBusy(macBusy), .divBusy(divBusy), .exIsLoad(exIsLoad), .exWrEn(exWrEn),
    .exDestReg(exDestReg), .idSrcA(idSrcA), .idSrcB(idSrcB),
    .fetchPayload(fetchPayload), .holdVec(holdVec), .flushOut(flushOut),
    .loadUseReq(loadUseReq), .bndData(bndData)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    flushIn = 0; fetchWait = 0; macBusy = 0; divBusy = 0;
    exIsLoad = 0; exWrEn = 0; exDestReg = '0; idSrcA = '0; idSrcB = '0;
  endtask

  function automatic logic [DW-1:0] bnd(input int j);
    return bndData[j*DW +: DW];
  endfunction

  // leaves IF/ID=d, ID/EX=c, EX/MEM=b, MEM/WB=a
  task automatic fill(input logic [DW-1:0] a, b, c, d);
    idle();
    fetchPayload = a; step();
    fetchPayload = b; step();
    fetchPayload = c; step();
    fetchPayload = d; step();
  endtask

  task automatic t_reset();
    idle();
    #1;
    check(bndData == '0, "R1 regs in reset", bndData, 0);
    @(negedge clk); rstN = 1; #1;
    check(holdVec == 6'b000000, "R1 idle vector", holdVec, 0);
  endtask

  task automatic t_flow();
    fill(16'h0001, 16'h0002, 16'h0003, 16'h0004);
    check(bndData == {16'h0001, 16'h0002, 16'h0003, 16'h0004}, "R11 pass chain",
          bndData, {16'h0001, 16'h0002, 16'h0003, 16'h0004});
  endtask

  task automatic t_fetch();
    fill(16'h0011, 16'h0022, 16'h0033, 16'h0044);
    fetchWait = 1; fetchPayload = 16'h0055; #1;
    check(holdVec == 6'b000111, "R2 fetch vector", holdVec, 6'b000111);
    step();
    check(bnd(0) == 16'h0044, "R10 IF/ID held", bnd(0), 16'h0044);
    check(bnd(1) == 16'h0000, "R9 ID/EX bubble", bnd(1), 0);
    check(bnd(2) == 16'h0033, "R11 EX/MEM drains", bnd(2), 16'h0033);
    check(bnd(3) == 16'h0022, "R11 MEM/WB drains", bnd(3), 16'h0022);
    idle();
  endtask

  task automatic t_loaduse();
    idle();
    exIsLoad = 1; exWrEn = 1; exDestReg = 5'd5; idSrcA = 5'd5; idSrcB = 5'd9; #1;
    check(loadUseReq == 1, "R7 match srcA", loadUseReq, 1);
    check(holdVec == 6'b000111, "R3 decode vector", holdVec, 6'b000111);
    idSrcA = 5'd3; idSrcB = 5'd5; #1;
    check(loadUseReq == 1, "R7 match srcB", loadUseReq, 1);
    idSrcB = 5'd6; #1;
    check(loadUseReq == 0 && holdVec == 0, "R7 no match", {loadUseReq, holdVec}, 0);
    exDestReg = 5'd0; idSrcA = 5'd0; idSrcB = 5'd0; #1;
    check(loadUseReq == 0 && holdVec == 0, "R8 register zero", {loadUseReq, holdVec}, 0);
    exDestReg = 5'd7; idSrcA = 5'd7; exWrEn = 0; #1;
    check(loadUseReq == 0 && holdVec == 0, "R8 no write", {loadUseReq, holdVec}, 0);
    exWrEn = 1; exIsLoad = 0; #1;
    check(loadUseReq == 0 && holdVec == 0, "R8 not a load", {loadUseReq, holdVec}, 0);
    idle();
  endtask

  task automatic t_ex();
    fill(16'h0101, 16'h0202, 16'h0303, 16'h0404);
    macBusy = 1; fetchPayload = 16'h0505; #1;
    check(holdVec == 6'b001111, "R4 mac vector", holdVec, 6'b001111);
    step();
    check(bnd(0) == 16'h0404, "R10 IF/ID held", bnd(0), 16'h0404);
    check(bnd(1) == 16'h0303, "R10 ID/EX held", bnd(1), 16'h0303);
    check(bnd(2) == 16'h0000, "R9 EX/MEM bubble", bnd(2), 0);
    check(bnd(3) == 16'h0202, "R11 MEM/WB drains", bnd(3), 16'h0202);
    macBusy = 0; divBusy = 1; #1;
    check(holdVec == 6'b001111, "R4 div vector", holdVec, 6'b001111);
    idle();
  endtask

  task automatic t_priority();
    idle();
    fetchWait = 1; exIsLoad = 1; exWrEn = 1; exDestReg = 5'd4; idSrcA = 5'd4; divBusy = 1; #1;
    check(holdVec == 6'b001111, "R5 execute wins", holdVec, 6'b001111);
    divBusy = 0; #1;
    check(holdVec == 6'b000111, "R5 decode with fetch", holdVec, 6'b000111);
    idle();
  endtask

  task automatic t_flush();
    fill(16'h1111, 16'h2222, 16'h3333, 16'h4444);
    fetchWait = 1; macBusy = 1; flushIn = 1; #1;
    check(holdVec == 0 && flushOut == 1, "R6 flush vector", {flushOut, holdVec}, 7'h40);
    step();
    check(bndData == '0, "R6 regs cleared", bndData, 0);
    idle();
  endtask

  initial begin
    t_reset();
    t_flow();
    t_fetch();
    t_loaduse();
    t_ex();
    t_priority();
    t_flush();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule